// File: doc/BRIEF.md
# Parallel DMA Interface Register Block

This block is the host-facing register file of a 16-bit parallel interface card that moves data by DMA. The host writes and reads 16-bit words at a few fixed byte offsets. Offset 0x00 has two meanings. A write to it is a command word: it loads three function latches and the interrupt enable, launches DMA, and fires one-cycle strobes. A read from it returns a status word made of live device inputs, sticky event flags and the latched function bits.

A separate pulse register changes only the interrupt enable. A vector register holds the interrupt vector, and an output data register drives the cable. Reading the data offset returns the device's input word. The address and count datapath of the DMA engine sits outside this block. It talks to the block through a busy level and pulses for end-of-range, bus error and bus timeout.

A two-state machine tracks whether DMA is enabled. `DMA_IDLE` moves to `DMA_ARMED` on a command write with GO set (transition *arm*). `DMA_ARMED` returns to `DMA_IDLE` on an end-of-range pulse (transition *finish*). A master clear forces `DMA_IDLE` from either state (transition *abort*). A GO in the same cycle as end-of-range keeps the machine armed.

Top module: `pio_csr_block`

## Requirements
- R1: Registers sit at byte offsets 0x00 (command/status), 0x02 (data), 0x05 (vector, low byte) and 0x06 (pulse). A read of the pulse offset or of any other offset returns zero. A write to an unused offset changes nothing.
- R2: A command write loads interrupt enable from bit 6 and the function latches from bits 3..1. Status bit 6 reads the enable and status bits 3..1 read the latches. `fcn_out[2:0]` drives the latches for command bits 3..1.
- R3: A pulse-register write with bit 6 set sets interrupt enable. With bit 5 set it clears the enable. With both bits set, the set wins. No other state changes.
- R4: Command bits 15, 14 and 13 clear the end-of-range, attention and parity flags. A zero in those bits has no effect. When a flag's set event and its clear arrive in the same cycle, the flag stays set.
- R5: Status bit 14 becomes set on a rising edge of `attn_in`, seen one clock after the edge, and stays set until cleared. Status bit 13 is the live `attn_in` level.
- R6: Status bit 12 is a sticky flag for `perr_in`. Status bits 11..9 are the live `stat_in[2:0]`. Bit 8 reads 0. Bit 7 is `~dma_busy`. Bit 0 is the `VARIANT_ID` parameter.
- R7: A command write with bit 0 set produces a one-cycle `go_pulse`. It also takes the machine to `DMA_ARMED`, which drives `dma_en` high, and it clears the bus error and bus timeout flags.
- R8: A command write with bit 8 set produces a one-cycle `cyc_pulse` only if the machine is armed or the same write sets GO. Otherwise there is no pulse.
- R9: `dma_eor` sets status bit 15 and returns the machine to `DMA_IDLE`. `dma_berr` sets status bit 5 and `dma_terr` sets status bit 4.
- R10: A command write with bit 2 set produces a one-cycle `aclo_pulse`.
- R11: A command write with bit 12 set is a master clear. It ignores every other bit of that write, clears all registers, flags and the machine, and gives a one-cycle `dev_reset`.
- R12: `irq` is high while interrupt enable is 1 and either the end-of-range flag or the attention flag is set.
- R13: A write to offset 0x02 loads `dev_dout`, and a read of 0x02 returns `dev_din`. A write to 0x05 loads `vec_out` from data bits 7..0, and a read of 0x05 returns the vector in the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | One-cycle host write strobe |
| bus_addr | input | 5 | Host byte address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| dev_din | input | 16 | Device input data word |
| dev_dout | output | 16 | Output data register |
| vec_out | output | 8 | Interrupt vector register |
| fcn_out | output | 3 | Function latches to the device |
| go_pulse | output | 1 | One-cycle GO strobe |
| cyc_pulse | output | 1 | One-cycle forced DMA cycle strobe |
| aclo_pulse | output | 1 | One-cycle power-fail style strobe |
| dev_reset | output | 1 | One-cycle device reset strobe |
| dma_en | output | 1 | DMA enabled (machine armed) |
| dma_busy | input | 1 | DMA transfer active |
| dma_eor | input | 1 | End-of-range pulse |
| dma_berr | input | 1 | Bus error pulse during DMA |
| dma_terr | input | 1 | Bus timeout pulse during DMA |
| attn_in | input | 1 | Attention level from the device |
| perr_in | input | 1 | Parity error pulse from the device |
| stat_in | input | 3 | Live device status lines |
| irq | output | 1 | Level interrupt request |

## Verification
The bench holds `attn_in` high across a flag clear. A design that detects the level instead of the edge would set the attention flag again at once. It drives a parity event in the same cycle as its clear. A design that lets the clear win would lose that event. It writes zeros to the clear bits, which a design treating any write as a clear would fail.

It requests a forced cycle both while armed and while idle, to catch a design that does not gate the cycle strobe on DMA being enabled. It also fires a master clear that carries GO and enable bits along with it. A design that does not suppress those bits would leave DMA armed or interrupts enabled after the reset strobe.

// File: rtl/pio_csr_pkg.sv
package pio_csr_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned FCN_W  = 3;
    localparam int unsigned STS_W  = 3;

    localparam logic [ADDR_W-1:0] OFF_CSR   = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_DATA  = 5'h02;
    localparam logic [ADDR_W-1:0] OFF_VEC   = 5'h05;
    localparam logic [ADDR_W-1:0] OFF_PULSE = 5'h06;

    // command word bit positions
    localparam int unsigned B_CLR_EOR = 15;
    localparam int unsigned B_CLR_ATT = 14;
    localparam int unsigned B_CLR_PER = 13;
    localparam int unsigned B_MCLR    = 12;
    localparam int unsigned B_CYC     = 8;
    localparam int unsigned B_IEN     = 6;
    localparam int unsigned B_FCN_LO  = 1;
    localparam int unsigned B_ACLO    = 2;
    localparam int unsigned B_GO      = 0;
    // pulse register bit positions
    localparam int unsigned B_PSET    = 6;
    localparam int unsigned B_PCLR    = 5;

    // sticky flag indices
    localparam int unsigned FL_EOR  = 0;
    localparam int unsigned FL_ATT  = 1;
    localparam int unsigned FL_PERR = 2;
    localparam int unsigned FL_BERR = 3;
    localparam int unsigned FL_TERR = 4;
    localparam int unsigned NFLAG   = 5;

    typedef enum logic {
        DMA_IDLE  = 1'b0,
        DMA_ARMED = 1'b1
    } dma_state_e;
endpackage

// File: rtl/pio_sticky_flag.sv
module pio_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sclr,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (sclr) begin
            q <= 1'b0;
        end else begin
            q <= set | (q & ~clr);
        end
    end
endmodule

// File: rtl/pio_rise_det.sv
module pio_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl;
        end
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/pio_dma_fsm.sv
module pio_dma_fsm
    import pio_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mclr,
    input  logic go_req,
    input  logic cyc_req,
    input  logic eor,
    output logic dma_en,
    output logic go_pulse,
    output logic cyc_pulse
);
    dma_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DMA_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DMA_IDLE:  if (go_req)          state_d = DMA_ARMED;
            DMA_ARMED: if (eor && !go_req)  state_d = DMA_IDLE;
            default:                        state_d = DMA_IDLE;
        endcase
        if (mclr) state_d = DMA_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_pulse  <= 1'b0;
            cyc_pulse <= 1'b0;
        end else begin
            go_pulse  <= go_req;
            cyc_pulse <= cyc_req && ((state_q == DMA_ARMED) || go_req);
        end
    end

    assign dma_en = (state_q == DMA_ARMED);
endmodule

// File: rtl/pio_csr_block.sv
module pio_csr_block
    import pio_csr_pkg::*;
#(
    parameter logic        VARIANT_ID = 1'b1,
    parameter int unsigned VEC_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [WORD_W-1:0] dev_din,
    output logic [WORD_W-1:0] dev_dout,
    output logic [VEC_W-1:0]  vec_out,
    output logic [FCN_W-1:0]  fcn_out,
    output logic              go_pulse,
    output logic              cyc_pulse,
    output logic              aclo_pulse,
    output logic              dev_reset,
    output logic              dma_en,
    input  logic              dma_busy,
    input  logic              dma_eor,
    input  logic              dma_berr,
    input  logic              dma_terr,
    input  logic              attn_in,
    input  logic              perr_in,
    input  logic [STS_W-1:0]  stat_in,
    output logic              irq
);
    localparam int unsigned VEC_PAD = WORD_W - VEC_W;

    logic hit_csr, mclr, ctl_wr, pls_wr, dat_wr, vec_wr;
    logic ien_q;
    logic [FCN_W-1:0] fcn_q;
    logic [WORD_W-1:0] dout_q;
    logic [VEC_W-1:0] vec_q;
    logic aclo_q, rst_q;
    logic attn_rise;
    logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
    logic [WORD_W-1:0] status;

    // address decode
    assign hit_csr = bus_wr && (bus_addr == OFF_CSR);
    assign mclr    = hit_csr &&  bus_wdata[B_MCLR];
    assign ctl_wr  = hit_csr && !bus_wdata[B_MCLR];
    assign pls_wr  = bus_wr && (bus_addr == OFF_PULSE);
    assign dat_wr  = bus_wr && (bus_addr == OFF_DATA);
    assign vec_wr  = bus_wr && (bus_addr == OFF_VEC);

    // interrupt enable: command load or atomic pulse set/clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (mclr) begin
            ien_q <= 1'b0;
        end else if (ctl_wr) begin
            ien_q <= bus_wdata[B_IEN];
        end else if (pls_wr) begin
            if (bus_wdata[B_PSET])      ien_q <= 1'b1;
            else if (bus_wdata[B_PCLR]) ien_q <= 1'b0;
        end
    end

    // function latches, data, vector and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcn_q  <= '0;
            dout_q <= '0;
            vec_q  <= '0;
            aclo_q <= 1'b0;
            rst_q  <= 1'b0;
        end else begin
            aclo_q <= ctl_wr && bus_wdata[B_ACLO];
            rst_q  <= mclr;
            if (mclr) begin
                fcn_q  <= '0;
                dout_q <= '0;
                vec_q  <= '0;
            end else begin
                if (ctl_wr) fcn_q  <= bus_wdata[B_FCN_LO +: FCN_W];
                if (dat_wr) dout_q <= bus_wdata;
                if (vec_wr) vec_q  <= bus_wdata[VEC_W-1:0];
            end
        end
    end

    pio_rise_det u_attn_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (attn_in),
        .rise (attn_rise)
    );

    // sticky flag sources and clears
    always_comb begin
        flag_set[FL_EOR]  = dma_eor;
        flag_set[FL_ATT]  = attn_rise;
        flag_set[FL_PERR] = perr_in;
        flag_set[FL_BERR] = dma_berr;
        flag_set[FL_TERR] = dma_terr;
        flag_clr[FL_EOR]  = ctl_wr && bus_wdata[B_CLR_EOR];
        flag_clr[FL_ATT]  = ctl_wr && bus_wdata[B_CLR_ATT];
        flag_clr[FL_PERR] = ctl_wr && bus_wdata[B_CLR_PER];
        flag_clr[FL_BERR] = ctl_wr && bus_wdata[B_GO];
        flag_clr[FL_TERR] = ctl_wr && bus_wdata[B_GO];
    end

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        pio_sticky_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .sclr (mclr),
            .set  (flag_set[gi]),
            .clr  (flag_clr[gi]),
            .q    (flag_q[gi])
        );
    end

    pio_dma_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mclr     (mclr),
        .go_req   (ctl_wr && bus_wdata[B_GO]),
        .cyc_req  (ctl_wr && bus_wdata[B_CYC]),
        .eor      (dma_eor),
        .dma_en   (dma_en),
        .go_pulse (go_pulse),
        .cyc_pulse(cyc_pulse)
    );

    assign status = {flag_q[FL_EOR], flag_q[FL_ATT], attn_in, flag_q[FL_PERR],
                     stat_in, 1'b0, ~dma_busy, ien_q,
                     flag_q[FL_BERR], flag_q[FL_TERR], fcn_q, VARIANT_ID};

    always_comb begin
        unique case (bus_addr)
            OFF_CSR:  bus_rdata = status;
            OFF_DATA: bus_rdata = dev_din;
            OFF_VEC:  bus_rdata = {{VEC_PAD{1'b0}}, vec_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign dev_dout   = dout_q;
    assign vec_out    = vec_q;
    assign fcn_out    = fcn_q;
    assign aclo_pulse = aclo_q;
    assign dev_reset  = rst_q;
    assign irq        = ien_q && (flag_q[FL_EOR] || flag_q[FL_ATT]);
endmodule

// File: rtl/pio_csr_chk.sv
module pio_csr_chk
    import pio_csr_pkg::*;
#(
    parameter int unsigned VEC_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [VEC_W-1:0]  vec_out,
    input logic [FCN_W-1:0]  fcn_out,
    input logic              go_pulse,
    input logic              cyc_pulse,
    input logic              aclo_pulse,
    input logic              dev_reset,
    input logic              dma_en,
    input logic              dma_eor,
    input logic              irq
);
    // R7
    go_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |-> dma_en);

    // R8
    cyc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_pulse |-> ($past(dma_en) || go_pulse));

    // R9
    eor_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_eor && dma_en && !(bus_wr && bus_addr == OFF_CSR && bus_wdata[B_GO]))
        |=> !dma_en);

    // R10
    aclo_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aclo_pulse |-> fcn_out[1]);

    // R11
    mclr_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> (!dma_en && fcn_out == '0 && vec_out == '0 && !irq && !go_pulse));
endmodule

bind pio_csr_block pio_csr_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .vec_out   (vec_out),
    .fcn_out   (fcn_out),
    .go_pulse  (go_pulse),
    .cyc_pulse (cyc_pulse),
    .aclo_pulse(aclo_pulse),
    .dev_reset (dev_reset),
    .dma_en    (dma_en),
    .dma_eor   (dma_eor),
    .irq       (irq)
);

// File: tb/pio_csr_block_tb.sv
module pio_csr_block_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] dev_din = 16'hBEEF;
    logic [15:0] dev_dout;
    logic [7:0]  vec_out;
    logic [2:0]  fcn_out;
    logic go_pulse, cyc_pulse, aclo_pulse, dev_reset, dma_en, irq;
    logic dma_busy = 1'b0, dma_eor = 1'b0, dma_berr = 1'b0, dma_terr = 1'b0;
    logic attn_in = 1'b0, perr_in = 1'b0;
    logic [2:0] stat_in = 3'b101;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_csr_block u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_din(dev_din),
        .dev_dout(dev_dout), .vec_out(vec_out), .fcn_out(fcn_out),
        .go_pulse(go_pulse), .cyc_pulse(cyc_pulse), .aclo_pulse(aclo_pulse),
        .dev_reset(dev_reset), .dma_en(dma_en), .dma_busy(dma_busy),
        .dma_eor(dma_eor), .dma_berr(dma_berr), .dma_terr(dma_terr),
        .attn_in(attn_in), .perr_in(perr_in), .stat_in(stat_in), .irq(irq)
    );

    // {address, write data, expected status after the write}
    localparam logic [36:0] VECS [0:7] = '{
        {5'h00, 16'h004E, 16'h0ACF},  // R2 ien + all latches
        {5'h06, 16'h0020, 16'h0A8F},  // R3 clear enable
        {5'h06, 16'h0060, 16'h0ACF},  // R3 both bits: set wins
        {5'h06, 16'h0020, 16'h0A8F},  // R3 latches untouched
        {5'h00, 16'h0002, 16'h0A83},  // R2 single latch
        {5'h08, 16'hFFFF, 16'h0A83},  // R1 unused offset ignored
        {5'h05, 16'h00A5, 16'h0A83},  // R13 vector write
        {5'h00, 16'h0000, 16'h0A81}   // R2 all cleared
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 5'h00; bus_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 5'h00;
        #1;
    endtask

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            finish_run();
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R6 reset state and fixed fields
        chk("R6 reset status", bus_rdata, 16'h0A81);
        chk("R12 reset irq", {15'h0, irq}, 16'h0);
        chk("R7 reset dma_en", {15'h0, dma_en}, 16'h0);

        for (int i = 0; i < 8; i++) begin
            wr(VECS[i][36:32], VECS[i][31:16]);
            chk($sformatf("R2 table[%0d]", i), bus_rdata, VECS[i][15:0]);
        end
        chk("R2 fcn_out", {13'h0, fcn_out}, 16'h0000);

        // R13 vector and data registers
        rd(5'h05, r);   chk("R13 vector read", r, 16'h00A5);
        chk("R13 vec_out", {8'h0, vec_out}, 16'h00A5);
        wr(5'h02, 16'h1234);
        chk("R13 dev_dout", dev_dout, 16'h1234);
        rd(5'h02, r);   chk("R13 data read", r, 16'hBEEF);
        // R1 reads of pulse and unused offsets
        rd(5'h06, r);   chk("R1 pulse read", r, 16'h0000);
        rd(5'h08, r);   chk("R1 unused read", r, 16'h0000);

        // R5 attention edge, R12 interrupt
        wr(5'h00, 16'h0040);
        @(negedge clk); attn_in = 1'b1;
        tick();
        chk("R5 attention set", bus_rdata, 16'h6AC1);
        chk("R12 irq on attention", {15'h0, irq}, 16'h1);
        wr(5'h00, 16'h4040);
        chk("R4 attention clear with level held", bus_rdata, 16'h2AC1);
        chk("R12 irq dropped", {15'h0, irq}, 16'h0);
        tick(); tick();
        chk("R5 no re-set without edge", bus_rdata, 16'h2AC1);
        @(negedge clk); attn_in = 1'b0;
        @(negedge clk); attn_in = 1'b1;
        tick();
        chk("R5 second edge", bus_rdata, 16'h6AC1);
        @(negedge clk); attn_in = 1'b0;
        wr(5'h00, 16'h4000);
        chk("R4 attention cleared", bus_rdata, 16'h0A81);

        // R6 parity flag, R4 clear semantics
        @(negedge clk); perr_in = 1'b1;
        @(negedge clk); perr_in = 1'b0; #1;
        chk("R6 parity sticky", bus_rdata, 16'h1A81);
        wr(5'h00, 16'h0000);
        chk("R4 zero does not clear", bus_rdata, 16'h1A81);
        wr(5'h00, 16'h2000);
        chk("R4 parity cleared", bus_rdata, 16'h0A81);
        @(negedge clk);
        perr_in = 1'b1; bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 16'h2000;
        @(negedge clk);
        perr_in = 1'b0; bus_wr = 1'b0; bus_wdata = '0; #1;
        chk("R4 set beats clear", bus_rdata, 16'h1A81);
        wr(5'h00, 16'h2000);

        // R6 ready bit
        dma_busy = 1'b1; #1;
        chk("R6 ready low while busy", bus_rdata, 16'h0A01);
        dma_busy = 1'b0; #1;

        // R7 GO
        wr(5'h00, 16'h0001);
        chk("R7 go_pulse", {15'h0, go_pulse}, 16'h1);
        chk("R7 dma_en", {15'h0, dma_en}, 16'h1);
        tick();
        chk("R7 go_pulse one cycle", {15'h0, go_pulse}, 16'h0);

        // R8 forced cycle while armed
        wr(5'h00, 16'h0100);
        chk("R8 cycle while armed", {15'h0, cyc_pulse}, 16'h1);
        chk("R7 no go without bit 0", {15'h0, go_pulse}, 16'h0);

        // R9 bus error / timeout flags
        @(negedge clk); dma_berr = 1'b1;
        @(negedge clk); dma_berr = 1'b0; dma_terr = 1'b1;
        @(negedge clk); dma_terr = 1'b0; #1;
        chk("R9 berr and terr", bus_rdata, 16'h0AB1);

        // R9 end-of-range, R12 interrupt
        wr(5'h00, 16'h0040);
        @(negedge clk); dma_eor = 1'b1;
        @(negedge clk); dma_eor = 1'b0; #1;
        chk("R9 eor flag", bus_rdata, 16'h8AF1);
        chk("R9 disarmed", {15'h0, dma_en}, 16'h0);
        chk("R12 irq on eor", {15'h0, irq}, 16'h1);

        // R8 forced cycle while idle
        wr(5'h00, 16'h0140);
        chk("R8 no cycle while idle", {15'h0, cyc_pulse}, 16'h0);
        wr(5'h00, 16'h8000);
        chk("R4 eor cleared", bus_rdata, 16'h0AB1);
        chk("R12 irq off", {15'h0, irq}, 16'h0);
        wr(5'h00, 16'h0001);
        chk("R7 go clears berr/terr", bus_rdata, 16'h0A81);

        // R10 power-fail strobe
        wr(5'h00, 16'h0004);
        chk("R10 aclo_pulse", {15'h0, aclo_pulse}, 16'h1);
        chk("R10 latch readback", bus_rdata, 16'h0A85);
        tick();
        chk("R10 aclo one cycle", {15'h0, aclo_pulse}, 16'h0);

        // R11 master clear
        wr(5'h00, 16'h004E);
        @(negedge clk); perr_in = 1'b1;
        @(negedge clk); perr_in = 1'b0; #1;
        chk("R11 pre-clear status", bus_rdata, 16'h1ACF);
        wr(5'h00, 16'h1041);
        chk("R11 dev_reset", {15'h0, dev_reset}, 16'h1);
        chk("R11 status cleared", bus_rdata, 16'h0A81);
        chk("R11 disarmed", {15'h0, dma_en}, 16'h0);
        chk("R11 go suppressed", {15'h0, go_pulse}, 16'h0);
        chk("R11 data cleared", dev_dout, 16'h0000);
        chk("R11 vector cleared", {8'h0, vec_out}, 16'h0000);
        tick();
        chk("R11 dev_reset one cycle", {15'h0, dev_reset}, 16'h0);

        done = 1'b1;
        finish_run();
    end
endmodule